// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This controller brings a set of supply rails up and down in a fixed dependency order. Rail 0 is the voltage reference, rail 1 the core logic supply, rail 2 the analog supply, and rail 3 (the highest index) the I/O and digital switching supply. The controller drives one enable per rail. It watches one power-good flag per rail, which comes from an off-chip comparator. It enables a rail only after the rail below it has reported good without a break for a programmable number of cycles. Power-down runs the same chain from the top rail to the bottom. Before it releases the next rail down, it waits for each disabled rail's power-good to fall, or for a discharge timeout to expire.

A rail that never reports good within the power-good timeout aborts the bring-up. The controller sets a sticky fault and runs the normal reverse shutdown. A loss of power-good while all rails are running also starts the reverse shutdown, as does a stop request. A start is accepted only from the idle state, and only when every power-good flag reads low. A start that arrives during a shutdown is therefore dropped, and it is not remembered.

Top module: `pwr_rail_sequencer`

## Requirements
- R1: Enables rise strictly in index order, at most one rail changes per clock, and the enable vector is always a run of ones from bit 0 upward.
- R2: After reset, a start pulse sampled in idle while all power-good inputs are low sets the enable of rail 0 on that same clock edge.
- R3: With rail k enabled, the enable of rail k+1 rises on the first edge that samples power-good k high when the preceding `settleCount` samples of power-good k were also high. A low sample restarts that count.
- R4: `done` rises on the edge where the top rail completes its settle (as in R3), and stays high only while all enables are high.
- R5: If the rail being brought up has not advanced by the edge where PG_TIMEOUT+1 cycles have passed since its enable rose, its enable drops on that edge, `fault` rises, and the reverse shutdown starts.
- R6: `fault` stays high until reset, through later shutdowns and bring-ups, and reset clears it.
- R7: During shutdown the enables fall from the highest rail down. The next lower rail is disabled on the first edge that samples the just-disabled rail's power-good low.
- R8: If a disabled rail's power-good stays high, the next lower rail is disabled DIS_TIMEOUT+1 cycles after the previous disable.
- R9: A stop request sampled during bring-up or while running clears the highest enabled rail on that edge, without setting `fault`.
- R10: If any power-good reads low while all rails are running, the top enable falls and `done` drops on the next edge, without setting `fault`.
- R11: A start request sampled during shutdown, or in idle while any power-good is high, enables no rail.
- R12: During and after reset, all enables, `done` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to begin bring-up |
| stopReq | input | 1 | Request to begin orderly power-down |
| settleCount | input | CNT_W | Consecutive good samples required before advancing |
| pwrGood | input | NUM_RAILS | Per-rail power-good flags, index = sequence position |
| railEn | output | NUM_RAILS | Per-rail enables, index = sequence position |
| fault | output | 1 | Sticky power-good timeout flag |
| done | output | 1 | All rails up and settled |

## Verification
Each result is due a fixed number of edges after the edge that samples its cause. A start or a stop, or a power-good loss while running, shows on the enables on that sampling edge. The next rail follows the first good sample by `settleCount` edges. A fault appears PG_TIMEOUT+1 edges after the stuck rail's enable, and a discharge timeout ends DIS_TIMEOUT+1 edges after the previous disable. The bench models every rail with known rise and fall delays and keeps its own edge counter. It records the edge at which each enable changed, and it compares the gaps between those edges with values computed from these rules. It drives and samples half a period away from the rising edge.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_UP   = 2'd1,
    SEQ_ON   = 2'd2,
    SEQ_DOWN = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic goFirst;      // select rail 0, enable it, clear counters
    logic goNextUp;     // step up one rail, enable it, clear counters
    logic goDownStart;  // disable current rail, clear counters
    logic goNextDown;   // step down one rail, disable it, clear counters
    logic runUp;        // count timeout and settle
    logic runDown;      // count discharge time
    logic faultSet;     // raise sticky fault
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic pgCur;
    logic settleMet;
    logic upTimeout;
    logic dnTimeout;
    logic idxLast;
    logic idxZero;
    logic allPgLow;
    logic allPgHigh;
  } seqStatus_t;

endpackage

// File: rtl/pwrseq_datapath.sv
module pwrseq_datapath
  import pwrseq_pkg::*;
#(
  parameter int NUM_RAILS   = 4,
  parameter int CNT_W       = 8,
  parameter int PG_TIMEOUT  = 40,
  parameter int DIS_TIMEOUT = 30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           stb,
  input  logic [CNT_W-1:0]     settleCount,
  input  logic [NUM_RAILS-1:0] pwrGood,
  output seqStatus_t           stat,
  output logic [NUM_RAILS-1:0] railEn,
  output logic                 fault
);

  localparam int IDX_W   = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1;
  localparam int TMR_MAX = (PG_TIMEOUT > DIS_TIMEOUT) ? PG_TIMEOUT : DIS_TIMEOUT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NUM_RAILS - 1);
  localparam logic [NUM_RAILS-1:0] EN_ONE = {{(NUM_RAILS-1){1'b0}}, 1'b1};

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idxUp;
  logic [IDX_W-1:0] idxDn;
  logic [TMR_W-1:0] timer;
  logic [CNT_W-1:0] settleCnt;
  logic             anyMove;

  assign idxUp   = idx + 1'b1;
  assign idxDn   = idx - 1'b1;
  assign anyMove = stb.goFirst | stb.goNextUp | stb.goDownStart | stb.goNextDown;

  // rail index and enable vector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx    <= '0;
      railEn <= '0;
    end else if (stb.goFirst) begin
      idx    <= '0;
      railEn <= EN_ONE;
    end else if (stb.goNextUp) begin
      idx           <= idxUp;
      railEn[idxUp] <= 1'b1;
    end else if (stb.goDownStart) begin
      railEn[idx] <= 1'b0;
    end else if (stb.goNextDown) begin
      idx           <= idxDn;
      railEn[idxDn] <= 1'b0;
    end
  end

  // timeout / discharge timer and settle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer     <= '0;
      settleCnt <= '0;
    end else if (anyMove) begin
      timer     <= '0;
      settleCnt <= '0;
    end else begin
      if (stb.runUp || stb.runDown) begin
        timer <= timer + 1'b1;
      end
      if (stb.runUp) begin
        if (!stat.pgCur) begin
          settleCnt <= '0;
        end else if (settleCnt != settleCount) begin
          settleCnt <= settleCnt + 1'b1;
        end
      end
    end
  end

  // sticky fault
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fault <= 1'b0;
    end else if (stb.faultSet) begin
      fault <= 1'b1;
    end
  end

  always_comb begin
    stat.pgCur     = pwrGood[idx];
    stat.settleMet = (settleCnt == settleCount);
    stat.upTimeout = (timer == TMR_W'(PG_TIMEOUT));
    stat.dnTimeout = (timer == TMR_W'(DIS_TIMEOUT));
    stat.idxLast   = (idx == IDX_TOP);
    stat.idxZero   = (idx == '0);
    stat.allPgLow  = (pwrGood == '0);
    stat.allPgHigh = (&pwrGood);
  end

  // enables always form a run of ones from rail 0
  assert_thermometer_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((railEn & (railEn + EN_ONE)) == '0));

  // never more than one enable changes per edge
  assert_single_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (railEn != $past(railEn)) |-> ($countones(railEn ^ $past(railEn)) == 1));

  // timer never runs past the longer window
  assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (timer <= TMR_W'(TMR_MAX)));

  // fault is sticky
  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> fault);

  // a rail only comes on when the rail below it was good on that edge
  generate
    for (genvar k = 1; k < NUM_RAILS; k++) begin : gRiseCheck
      assert_rise_needs_pg_R3: assert property (@(posedge clk) disable iff (!rstN)
        $rose(railEn[k]) |-> $past(pwrGood[k-1]));
    end
  endgenerate

endmodule

// File: rtl/pwrseq_control.sv
module pwrseq_control
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       stopReq,
  input  seqStatus_t stat,
  output seqStrobe_t stb,
  output logic       done
);

  seqState_t state;
  seqState_t stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_OFF;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      SEQ_OFF: begin
        if (startReq && stat.allPgLow) begin
          stb.goFirst = 1'b1;
          stateNext   = SEQ_UP;
        end
      end
      SEQ_UP: begin
        if (stopReq) begin
          stb.goDownStart = 1'b1;
          stateNext       = SEQ_DOWN;
        end else if (stat.pgCur && stat.settleMet) begin
          if (stat.idxLast) begin
            stateNext = SEQ_ON;
          end else begin
            stb.goNextUp = 1'b1;
          end
        end else if (stat.upTimeout) begin
          stb.faultSet    = 1'b1;
          stb.goDownStart = 1'b1;
          stateNext       = SEQ_DOWN;
        end else begin
          stb.runUp = 1'b1;
        end
      end
      SEQ_ON: begin
        if (stopReq || !stat.allPgHigh) begin
          stb.goDownStart = 1'b1;
          stateNext       = SEQ_DOWN;
        end
      end
      SEQ_DOWN: begin
        if (!stat.pgCur || stat.dnTimeout) begin
          if (stat.idxZero) begin
            stateNext = SEQ_OFF;
          end else begin
            stb.goNextDown = 1'b1;
          end
        end else begin
          stb.runDown = 1'b1;
        end
      end
      default: stateNext = SEQ_OFF;
    endcase
  end

  assign done = (state == SEQ_ON);

  // start during shutdown never reopens bring-up
  assert_start_ignored_down_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_DOWN && startReq) |=> (state != SEQ_UP));

  // start in idle with any power-good high is refused
  assert_start_needs_low_pg_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_OFF && !stat.allPgLow) |=> (state == SEQ_OFF));

  // running state only left towards shutdown
  assert_on_exits_to_down_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_ON) |=> (state == SEQ_ON || state == SEQ_DOWN));

endmodule

// File: rtl/pwr_rail_sequencer.sv
module pwr_rail_sequencer
  import pwrseq_pkg::*;
#(
  parameter int NUM_RAILS   = 4,
  parameter int CNT_W       = 8,
  parameter int PG_TIMEOUT  = 40,
  parameter int DIS_TIMEOUT = 30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 stopReq,
  input  logic [CNT_W-1:0]     settleCount,
  input  logic [NUM_RAILS-1:0] pwrGood,
  output logic [NUM_RAILS-1:0] railEn,
  output logic                 fault,
  output logic                 done
);

  seqStrobe_t stb;
  seqStatus_t stat;

  pwrseq_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .stopReq  (stopReq),
    .stat     (stat),
    .stb      (stb),
    .done     (done)
  );

  pwrseq_datapath #(
    .NUM_RAILS   (NUM_RAILS),
    .CNT_W       (CNT_W),
    .PG_TIMEOUT  (PG_TIMEOUT),
    .DIS_TIMEOUT (DIS_TIMEOUT)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .settleCount (settleCount),
    .pwrGood     (pwrGood),
    .stat        (stat),
    .railEn      (railEn),
    .fault       (fault)
  );

  // done only with every rail enabled
  assert_done_all_on_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (&railEn));

endmodule

// File: tb/tb_pwr_rail_sequencer.sv
module tb_pwr_rail_sequencer;

  localparam int N   = 4;
  localparam int CW  = 8;
  localparam int PGT = 40;
  localparam int DT  = 30;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          stopReq = 1'b0;
  logic [CW-1:0] settleCount = '0;
  logic [N-1:0]  pwrGood;
  logic [N-1:0]  railEn;
  logic          fault;
  logic          done;

  logic [N-1:0]  pgModel = '0;
  logic [N-1:0]  forceLow = '0;
  logic [N-1:0]  forceHigh = '0;
  int dly[N];
  int fall[N];
  int onCnt[N];
  int offCnt[N];
  int upCyc[N];
  int dnCyc[N];
  int doneCyc;
  logic [N-1:0] prevEn = '0;
  logic prevDone = 1'b0;
  int cyc = 0;
  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  assign pwrGood = (pgModel & ~forceLow) | forceHigh;

  pwr_rail_sequencer #(
    .NUM_RAILS(N), .CNT_W(CW), .PG_TIMEOUT(PGT), .DIS_TIMEOUT(DT)
  ) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .settleCount(settleCount), .pwrGood(pwrGood), .railEn(railEn),
    .fault(fault), .done(done)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // rail model: good after dly cycles on, low after fall cycles off
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (railEn[i]) begin
        offCnt[i] = 0;
        onCnt[i]  = onCnt[i] + 1;
        if (onCnt[i] >= dly[i]) pgModel[i] = 1'b1;
      end else begin
        onCnt[i]  = 0;
        offCnt[i] = offCnt[i] + 1;
        if (offCnt[i] >= fall[i]) pgModel[i] = 1'b0;
      end
    end
  end

  // edge recorder
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (railEn[i] && !prevEn[i]) upCyc[i] = cyc;
      if (!railEn[i] && prevEn[i]) dnCyc[i] = cyc;
    end
    if (done && !prevDone) doneCyc = cyc;
    prevEn   = railEn;
    prevDone = done;
  end

  function automatic int expUpGap(int d, int s);
    return d + s;
  endfunction

  function automatic int expDownGap(int f);
    return f;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic pulseStart();
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
  endtask

  task automatic pulseStop();
    stopReq = 1'b1;
    tick();
    stopReq = 1'b0;
  endtask

  task automatic waitDone();
    int g = 0;
    while (!done && g < 600) begin tick(); g++; end
  endtask

  task automatic waitOff();
    int g = 0;
    while (railEn != '0 && g < 600) begin tick(); g++; end
  endtask

  task automatic waitRail(int k);
    int g = 0;
    while (!railEn[k] && g < 600) begin tick(); g++; end
  endtask

  task automatic setTiming(int d, int f);
    for (int i = 0; i < N; i++) begin dly[i] = d; fall[i] = f; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    int seedDummy;
    int s;
    int x;
    int e0;
    seedDummy = $urandom(32'h5EC0_0042);
    setTiming(2, 2);
    for (int i = 0; i < N; i++) begin onCnt[i] = 0; offCnt[i] = 0; end

    // reset state, R12
    tick(); tick();
    check("R12", "railEn in reset", int'(railEn), 0);
    check("R12", "done in reset", int'(done), 0);
    check("R12", "fault in reset", int'(fault), 0);
    rstN = 1'b1;
    tick(); tick();
    check("R12", "railEn after reset", int'(railEn), 0);

    // random bring-up / stop cycles, R1 R2 R3 R4 R7 R9
    for (int it = 0; it < 8; it++) begin
      s = int'($urandom_range(0, 12));
      settleCount = CW'(s);
      for (int i = 0; i < N; i++) begin
        dly[i]  = int'($urandom_range(1, 6));
        fall[i] = int'($urandom_range(1, 5));
      end
      pulseStart();
      check("R2", "rail 0 on at start edge", int'(railEn), 1);
      check("R2", "rail 0 rise edge", upCyc[0], cyc);
      waitDone();
      for (int k = 1; k < N; k++)
        check("R1", "R3 gap to next rail", upCyc[k] - upCyc[k-1], expUpGap(dly[k-1], s));
      check("R4", "done after top rail settle", doneCyc - upCyc[N-1], expUpGap(dly[N-1], s));
      check("R4", "all rails on with done", int'(railEn), (1 << N) - 1);
      pulseStop();
      check("R9", "top rail off at stop edge", int'(railEn), (1 << (N-1)) - 1);
      check("R9", "done low after stop", int'(done), 0);
      x = cyc;
      waitOff();
      for (int k = N - 1; k >= 1; k--)
        check("R7", "reverse gap", dnCyc[k-1] - dnCyc[k], expDownGap(fall[k]));
      check("R9", "no fault on stop", int'(fault), 0);
      check("R7", "top rail fell at stop edge", dnCyc[N-1], x);
      repeat (8) tick();
    end

    // settle restart on power-good glitch, R3
    setTiming(2, 2);
    settleCount = CW'(5);
    pulseStart();
    e0 = cyc;
    while (cyc < e0 + 4) tick();
    forceLow[0] = 1'b1;
    tick();
    forceLow[0] = 1'b0;
    waitRail(1);
    check("R3", "glitch restarts settle", upCyc[1] - e0, 6 + 5);
    pulseStop();
    waitOff();
    repeat (8) tick();

    // stop during bring-up, R9
    setTiming(2, 2);
    dly[1] = 3;
    settleCount = CW'(1);
    pulseStart();
    waitRail(1);
    pulseStop();
    check("R9", "stop in bring-up drops rail 1", int'(railEn), 1);
    check("R9", "stop in bring-up no fault", int'(fault), 0);
    waitOff();
    repeat (8) tick();

    // power-good loss while running, R10
    setTiming(2, 2);
    settleCount = CW'(2);
    pulseStart();
    waitDone();
    tick();
    forceLow[1] = 1'b1;
    tick();
    check("R10", "top rail off after pg loss", int'(railEn), 7);
    check("R10", "done low after pg loss", int'(done), 0);
    waitOff();
    forceLow[1] = 1'b0;
    check("R10", "no fault on pg loss", int'(fault), 0);
    repeat (8) tick();

    // timeout fault, R5 R6
    setTiming(2, 2);
    settleCount = CW'(3);
    forceLow[2] = 1'b1;
    pulseStart();
    waitRail(2);
    e0 = upCyc[2];
    while (cyc < e0 + PGT) tick();
    check("R5", "rail 2 still on before timeout", int'(railEn), 7);
    check("R5", "no fault before timeout", int'(fault), 0);
    tick();
    check("R5", "fault at timeout edge", int'(fault), 1);
    check("R5", "rail 2 off at timeout edge", int'(railEn), 3);
    waitOff();
    check("R6", "fault held after shutdown", int'(fault), 1);
    forceLow[2] = 1'b0;
    repeat (8) tick();
    pulseStart();
    waitDone();
    check("R6", "fault held through bring-up", int'(fault), 1);
    check("R4", "done after retry", int'(done), 1);
    pulseStop();
    waitOff();
    repeat (8) tick();
    rstN = 1'b0;
    tick();
    rstN = 1'b1;
    tick();
    check("R6", "reset clears fault", int'(fault), 0);

    // discharge timeout and ignored starts, R8 R11
    setTiming(2, 2);
    settleCount = CW'(2);
    pulseStart();
    waitDone();
    forceHigh[3] = 1'b1;
    pulseStop();
    x = cyc;
    tick(); tick();
    pulseStart();
    while (cyc < x + DT) tick();
    check("R8", "rail 2 held during discharge wait", int'(railEn), 7);
    check("R11", "start in shutdown ignored", int'(railEn[3]), 0);
    tick();
    check("R8", "rail 2 off after discharge timeout", int'(railEn), 3);
    waitOff();
    repeat (3) tick();
    check("R11", "no restart after shutdown", int'(railEn), 0);
    pulseStart();
    repeat (3) tick();
    check("R11", "start refused with pg high", int'(railEn), 0);
    forceHigh[3] = 1'b0;
    repeat (3) tick();
    pulseStart();
    check("R2", "start accepted once pg low", int'(railEn), 1);
    waitDone();
    pulseStop();
    waitOff();
    repeat (4) tick();

    summary();
  end

endmodule